// File: doc/BRIEF.md
# Outstanding Request Age Watchdog

This block holds a small table of outstanding memory requests and checks it periodically for requests that have waited too long. The table is organised by cache line: each line entry records a line address and a queue of up to `DEPTH` requests, each request carrying the cycle stamp taken when it was inserted. A request is inserted by presenting its line address; it joins the queue of a line that already holds that address, or it opens the lowest-numbered empty line. A remove pops the oldest request of the line with the matching address.

The check is armed lazily. An accepted insert arms it, unless it is already armed or the system is draining. Once armed, a timer runs for `PERIOD` cycles and then a scan walks the table one request slot per clock. Every queued request is compared with the programmable threshold, using the age `now - issue` taken modulo 2^CW so that a wrap of the free-running cycle counter does no harm. The first offending request sets a sticky deadlock flag and is captured in a diagnostic record. During the same scan the per-line queue lengths are summed and compared with a separately kept outstanding counter; a mismatch sets a sticky error. At the end of a scan the block pulses `scan_done`. It rearms only if requests remain outstanding.

Both the insert and the remove inputs are valid/ready streams. A transfer takes place on a rising clock edge where valid and ready are both high. Ready never depends on valid. Both readies are low for the whole scan, so the table and the counter stay frozen while they are being recounted. Insert ready is also low when the matching line's queue is full, and when no line matches and no line is free.

Top module: `req_age_watchdog`

## Requirements
- R1: A queued request trips the check when `(now - issue) mod 2^CW` is greater than or equal to `thr`. A request younger than `thr` is skipped, including when `now` has wrapped past zero since it was issued.
- R2: Each scan examines every queued request of every line, not only the front request of each line.
- R3: `deadlock` stays high until reset once it is set. The record (`rec_addr`, `rec_qlen`, `rec_now`, `rec_issue`, `rec_age`) holds the first offending request met in scan order (line 0 upward, front slot first). Later trips do not change it.
- R4: An accepted insert arms the check only when it is not armed and `drain` is low. An insert while armed does not restart the timer.
- R5: A scan starts `PERIOD` cycles after the arming edge and takes `LINES*DEPTH` cycles. `scan_done` is a one-cycle pulse that is visible after the edge `PERIOD+LINES*DEPTH` cycles after the arming edge.
- R6: At the end of a scan the block rearms, with the next `scan_done` `PERIOD+LINES*DEPTH` cycles later, if the outstanding count is nonzero. Otherwise `armed` falls at that edge.
- R7: `count_err` is set, and stays set, when a scan's sum of per-line queue lengths differs from the outstanding counter. It stays low under legal traffic.
- R8: `ins_ready` is low during a scan. It is also low when the matching line holds `DEPTH` requests, and when no line matches and no line is free. A new address takes the lowest-numbered empty line.
- R9: An accepted remove pops the oldest request of the matching line. A remove whose address matches no line changes nothing. `rm_ready` is low during a scan.
- R10: After reset, `deadlock`, `count_err`, `armed` and `scan_done` are low, the table is empty, and both readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | CW | Free-running cycle count |
| drain | input | 1 | System is draining; blocks arming |
| thr | input | CW | Age threshold in cycles |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert can be accepted |
| ins_addr | input | AW | Line address of inserted request |
| rm_valid | input | 1 | Remove valid |
| rm_ready | output | 1 | Remove can be accepted |
| rm_addr | input | AW | Line address whose oldest request completes |
| armed | output | 1 | A check is scheduled or running |
| scan_done | output | 1 | One-cycle pulse at the end of each scan |
| deadlock | output | 1 | Sticky: some request reached the threshold |
| count_err | output | 1 | Sticky: recount disagreed with the counter |
| rec_addr | output | AW | Line address of the first offender |
| rec_qlen | output | QW | Queue length of that line at the trip |
| rec_now | output | CW | Cycle count at the trip |
| rec_issue | output | CW | Issue stamp of the offender |
| rec_age | output | CW | Modular difference of the two |

## Verification
The threshold comparison is swept over several thresholds, each with ages one below, equal to and one above the threshold, at issue stamps both far from and just below the counter wrap. This separates `>` from `>=`, a signed comparison from a modular one, and a wrap-induced false trip from a genuine one. A two-request line whose back request is older than its front shows whether every slot is scanned. Two lines that both trip show whether only the first offender is latched. Arming is exercised with inserts during drain, a second insert mid-period, and removes that match and that miss; the spacing of `scan_done` and the fall of `armed` show when scheduling is right. Full-line and full-table inserts and probes during a scan check the back-pressure rules.

// File: rtl/raw_pkg.sv
package raw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SCAN = 2'd2
  } raw_state_e;
endpackage

// File: rtl/raw_line.sv
// One line entry: address plus an in-order queue of issue stamps.
module raw_line #(
  parameter int AW    = 8,
  parameter int CW    = 16,
  parameter int DEPTH = 2,
  parameter int QW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [AW-1:0]              push_addr,
  input  logic [CW-1:0]              push_stamp,
  output logic [QW-1:0]              cnt,
  output logic [AW-1:0]              addr,
  output logic [DEPTH-1:0][CW-1:0]   stamps
);
  logic [DEPTH-1:0][CW-1:0] stamps_nxt;
  logic [QW-1:0]            cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (push && !pop) cnt_nxt = cnt + QW'(1);
    if (pop && !push) cnt_nxt = cnt - QW'(1);
    for (int d = 0; d < DEPTH; d++) begin
      stamps_nxt[d] = stamps[d];
      if (pop) begin
        if (d < DEPTH - 1) stamps_nxt[d] = stamps[d+1];
        if (push && (QW'(d) == cnt - QW'(1))) stamps_nxt[d] = push_stamp;
      end else if (push && (QW'(d) == cnt)) begin
        stamps_nxt[d] = push_stamp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      addr   <= '0;
      stamps <= '0;
    end else begin
      cnt    <= cnt_nxt;
      stamps <= stamps_nxt;
      if (push && cnt == '0) addr <= push_addr;
    end
  end
endmodule

// File: rtl/raw_scan.sv
// Arming, period timer, serial scan, trip capture and recount check.
module raw_scan
  import raw_pkg::*;
#(
  parameter int AW     = 8,
  parameter int CW     = 16,
  parameter int LINES  = 4,
  parameter int DEPTH  = 2,
  parameter int PERIOD = 64,
  parameter int QW     = 2,
  parameter int OW     = 4,
  parameter int LW     = 2,
  parameter int SW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_fire,
  input  logic          drain,
  input  logic [CW-1:0] now,
  input  logic [CW-1:0] thr,
  input  logic          slot_valid,
  input  logic [CW-1:0] slot_stamp,
  input  logic [AW-1:0] line_addr,
  input  logic [QW-1:0] line_cnt,
  input  logic [OW-1:0] outstanding,
  output logic          armed,
  output logic          scanning,
  output logic [LW-1:0] line_i,
  output logic [SW-1:0] slot_i,
  output logic          scan_done,
  output logic          deadlock,
  output logic          count_err,
  output logic [AW-1:0] rec_addr,
  output logic [QW-1:0] rec_qlen,
  output logic [CW-1:0] rec_now,
  output logic [CW-1:0] rec_issue,
  output logic [CW-1:0] rec_age
);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  raw_state_e    st;
  logic [TW-1:0] tmr;
  logic [OW-1:0] sum;
  logic [OW-1:0] sum_nxt;
  logic [CW-1:0] age;
  logic          trip;
  logic          last;

  assign age      = now - slot_stamp;
  assign trip     = slot_valid && (age >= thr);
  assign last     = (line_i == LW'(LINES - 1)) && (slot_i == SW'(DEPTH - 1));
  assign sum_nxt  = sum + ((slot_i == '0) ? OW'(line_cnt) : '0);
  assign armed    = (st != ST_IDLE);
  assign scanning = (st == ST_SCAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tmr       <= '0;
      sum       <= '0;
      line_i    <= '0;
      slot_i    <= '0;
      scan_done <= 1'b0;
      deadlock  <= 1'b0;
      count_err <= 1'b0;
      rec_addr  <= '0;
      rec_qlen  <= '0;
      rec_now   <= '0;
      rec_issue <= '0;
      rec_age   <= '0;
    end else begin
      scan_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (ins_fire && !drain) begin
            st  <= ST_WAIT;
            tmr <= TW'(PERIOD - 1);
          end
        end
        ST_WAIT: begin
          if (tmr == '0) begin
            st     <= ST_SCAN;
            line_i <= '0;
            slot_i <= '0;
            sum    <= '0;
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        ST_SCAN: begin
          if (trip && !deadlock) begin
            deadlock  <= 1'b1;
            rec_addr  <= line_addr;
            rec_qlen  <= line_cnt;
            rec_now   <= now;
            rec_issue <= slot_stamp;
            rec_age   <= age;
          end
          sum <= sum_nxt;
          if (slot_i == SW'(DEPTH - 1)) begin
            slot_i <= '0;
            line_i <= line_i + LW'(1);
          end else begin
            slot_i <= slot_i + SW'(1);
          end
          if (last) begin
            scan_done <= 1'b1;
            if (sum_nxt != outstanding) count_err <= 1'b1;
            if (outstanding != '0) begin
              st  <= ST_WAIT;
              tmr <= TW'(PERIOD - 1);
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/req_age_watchdog.sv
module req_age_watchdog
  import raw_pkg::*;
#(
  parameter int AW     = 8,
  parameter int CW     = 16,
  parameter int LINES  = 4,
  parameter int DEPTH  = 2,
  parameter int PERIOD = 64,
  localparam int QW    = $clog2(DEPTH + 1),
  localparam int OW    = $clog2(LINES * DEPTH + 1),
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now,
  input  logic          drain,
  input  logic [CW-1:0] thr,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [AW-1:0] ins_addr,
  input  logic          rm_valid,
  output logic          rm_ready,
  input  logic [AW-1:0] rm_addr,
  output logic          armed,
  output logic          scan_done,
  output logic          deadlock,
  output logic          count_err,
  output logic [AW-1:0] rec_addr,
  output logic [QW-1:0] rec_qlen,
  output logic [CW-1:0] rec_now,
  output logic [CW-1:0] rec_issue,
  output logic [CW-1:0] rec_age
);
  logic [QW-1:0]            cnt_a  [LINES];
  logic [AW-1:0]            addr_a [LINES];
  logic [DEPTH-1:0][CW-1:0] st_a   [LINES];

  logic [LINES-1:0] hit;
  logic [LINES-1:0] rm_hit;
  logic [LINES-1:0] push;
  logic [LINES-1:0] pop;
  logic             any_hit;
  logic             hit_room;
  logic             free_ok;
  logic [LW-1:0]    free_idx;
  logic             ins_fire;
  logic             rm_eff;
  logic             scanning;
  logic [OW-1:0]    outstanding;

  logic [LW-1:0]    line_i;
  logic [SW-1:0]    slot_i;
  logic             slot_valid;
  logic [CW-1:0]    slot_stamp;
  logic [AW-1:0]    line_addr;
  logic [QW-1:0]    line_cnt;

  // Address match and lowest free line search.
  always_comb begin
    hit      = '0;
    rm_hit   = '0;
    hit_room = 1'b0;
    free_ok  = 1'b0;
    free_idx = '0;
    for (int l = LINES - 1; l >= 0; l--) begin
      if (cnt_a[l] == '0) begin
        free_ok  = 1'b1;
        free_idx = LW'(l);
      end
    end
    for (int l = 0; l < LINES; l++) begin
      if (cnt_a[l] != '0 && addr_a[l] == ins_addr) begin
        hit[l] = 1'b1;
        if (cnt_a[l] < QW'(DEPTH)) hit_room = 1'b1;
      end
      rm_hit[l] = (cnt_a[l] != '0) && (addr_a[l] == rm_addr);
    end
  end

  assign any_hit   = |hit;
  assign ins_ready = !scanning && (any_hit ? hit_room : free_ok);
  assign rm_ready  = !scanning;
  assign ins_fire  = ins_valid && ins_ready;
  assign rm_eff    = |pop;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign push[g] = ins_fire && (any_hit ? hit[g] : (free_idx == LW'(g)));
    assign pop[g]  = rm_valid && rm_ready && rm_hit[g];

    raw_line #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .QW(QW)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push[g]),
      .pop        (pop[g]),
      .push_addr  (ins_addr),
      .push_stamp (now),
      .cnt        (cnt_a[g]),
      .addr       (addr_a[g]),
      .stamps     (st_a[g])
    );
  end

  // Running outstanding counter, kept apart from the per-line counts.
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= '0;
    else        outstanding <= outstanding + OW'(ins_fire) - OW'(rm_eff);
  end

  // Slot selected by the scan index.
  assign line_cnt   = cnt_a[line_i];
  assign line_addr  = addr_a[line_i];
  assign slot_stamp = st_a[line_i][slot_i];
  assign slot_valid = QW'(slot_i) < line_cnt;

  raw_scan #(
    .AW(AW), .CW(CW), .LINES(LINES), .DEPTH(DEPTH), .PERIOD(PERIOD),
    .QW(QW), .OW(OW), .LW(LW), .SW(SW)
  ) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_fire    (ins_fire),
    .drain       (drain),
    .now         (now),
    .thr         (thr),
    .slot_valid  (slot_valid),
    .slot_stamp  (slot_stamp),
    .line_addr   (line_addr),
    .line_cnt    (line_cnt),
    .outstanding (outstanding),
    .armed       (armed),
    .scanning    (scanning),
    .line_i      (line_i),
    .slot_i      (slot_i),
    .scan_done   (scan_done),
    .deadlock    (deadlock),
    .count_err   (count_err),
    .rec_addr    (rec_addr),
    .rec_qlen    (rec_qlen),
    .rec_now     (rec_now),
    .rec_issue   (rec_issue),
    .rec_age     (rec_age)
  );
endmodule

// File: rtl/raw_chk.sv
module raw_chk #(
  parameter int AW  = 8,
  parameter int CW  = 16,
  parameter int OW  = 4,
  parameter int CAP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drain,
  input logic          ins_ready,
  input logic          rm_ready,
  input logic          armed,
  input logic          scan_done,
  input logic          deadlock,
  input logic          count_err,
  input logic [AW-1:0] rec_addr,
  input logic [CW-1:0] rec_age,
  input logic [OW-1:0] outstanding
);
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);

  assert_record_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> ($stable(rec_addr) && $stable(rec_age)));

  assert_no_arm_in_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && drain) |=> !armed);

  assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  assert_disarm_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> scan_done);

  assert_recount_agrees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !count_err);

  assert_ready_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> rm_ready);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= OW'(CAP));
endmodule

bind req_age_watchdog raw_chk #(.AW(AW), .CW(CW), .OW(OW), .CAP(LINES * DEPTH)) u_raw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drain       (drain),
  .ins_ready   (ins_ready),
  .rm_ready    (rm_ready),
  .armed       (armed),
  .scan_done   (scan_done),
  .deadlock    (deadlock),
  .count_err   (count_err),
  .rec_addr    (rec_addr),
  .rec_age     (rec_age),
  .outstanding (outstanding)
);

// File: tb/test_req_age_watchdog.sv
module test_req_age_watchdog;
  localparam int AW = 8, CW = 16, LINES = 4, DEPTH = 2, PERIOD = 8;
  localparam int SPAN = PERIOD + LINES * DEPTH;
  localparam int QW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] now = '0;
  logic          drain = 1'b0;
  logic [CW-1:0] thr = '0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [AW-1:0] ins_addr = '0;
  logic          rm_valid = 1'b0;
  logic          rm_ready;
  logic [AW-1:0] rm_addr = '0;
  logic          armed, scan_done, deadlock, count_err;
  logic [AW-1:0] rec_addr;
  logic [QW-1:0] rec_qlen;
  logic [CW-1:0] rec_now, rec_issue, rec_age;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  req_age_watchdog #(.AW(AW), .CW(CW), .LINES(LINES), .DEPTH(DEPTH), .PERIOD(PERIOD))
    i_req_age_watchdog (
    .clk(clk), .rst_n(rst_n), .now(now), .drain(drain), .thr(thr),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr),
    .rm_valid(rm_valid), .rm_ready(rm_ready), .rm_addr(rm_addr),
    .armed(armed), .scan_done(scan_done), .deadlock(deadlock), .count_err(count_err),
    .rec_addr(rec_addr), .rec_qlen(rec_qlen), .rec_now(rec_now),
    .rec_issue(rec_issue), .rec_age(rec_age)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ins_valid = 1'b0; rm_valid = 1'b0; drain = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic insert(logic [AW-1:0] a, logic [CW-1:0] stamp);
    now = stamp; ins_addr = a; ins_valid = 1'b1;
    #1;
    check("R8", "insert accepted", ins_ready, 1);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic remove(logic [AW-1:0] a);
    rm_addr = a; rm_valid = 1'b1;
    #1;
    check("R9", "remove accepted", rm_ready, 1);
    @(negedge clk);
    rm_valid = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (scan_done !== 1'b1 && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic trial(int thr_v, logic [CW-1:0] stamp, int dd);
    logic [CW-1:0] age_v;
    logic          exp_trip;
    int            k;
    do_reset();
    thr = CW'(thr_v);
    age_v = CW'(thr_v + dd);
    exp_trip = (age_v >= CW'(thr_v));
    insert(8'h21, stamp);
    now = stamp + age_v;
    wait_done(k);
    check("R5", "cycles arm to done", k, SPAN);
    check("R1", "trip decision", deadlock, exp_trip);
    if (exp_trip) begin
      check("R3", "rec_addr", rec_addr, 8'h21);
      check("R3", "rec_qlen", rec_qlen, 1);
      check("R3", "rec_issue", rec_issue, stamp);
      check("R3", "rec_now", rec_now, CW'(stamp + age_v));
      check("R3", "rec_age", rec_age, age_v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int k;
    int thr_list [5] = '{0, 1, 7, 300, 65535};
    logic [CW-1:0] stamp_list [2] = '{16'd10, 16'hFFF0};

    // R10: reset state
    do_reset();
    check("R10", "deadlock after reset", deadlock, 0);
    check("R10", "armed after reset", armed, 0);
    check("R10", "scan_done after reset", scan_done, 0);
    check("R10", "count_err after reset", count_err, 0);
    check("R10", "ins_ready after reset", ins_ready, 1);
    check("R10", "rm_ready after reset", rm_ready, 1);

    // R1 sweep: threshold boundary, both sides of the counter wrap
    foreach (thr_list[i]) begin
      foreach (stamp_list[s]) begin
        for (int dd = -1; dd <= 1; dd++) trial(thr_list[i], stamp_list[s], dd);
      end
    end

    // R2: back slot older than front slot; only the back slot trips
    do_reset();
    thr = 16'd40;
    insert(8'h30, 16'd100);
    insert(8'h30, 16'd50);
    now = 16'd120;
    wait_done(k);
    check("R2", "back slot tripped", deadlock, 1);
    check("R2", "rec_issue of back slot", rec_issue, 50);
    check("R2", "rec_qlen", rec_qlen, 2);
    check("R2", "rec_age", rec_age, 70);

    // R3 + R8 allocation: two offending lines, first in scan order is kept
    do_reset();
    thr = 16'd5;
    insert(8'h40, 16'd0);
    insert(8'h41, 16'd0);
    now = 16'd100;
    wait_done(k);
    check("R3", "first offender addr", rec_addr, 8'h40);
    @(negedge clk);
    now = 16'd200;
    wait_done(k);
    check("R6", "rearm period", k + 1, SPAN);
    check("R3", "flag sticky", deadlock, 1);
    check("R3", "record kept addr", rec_addr, 8'h40);
    check("R3", "record kept now", rec_now, 100);

    // R4, R6, R9: arming, drain, mid-period insert, removes
    do_reset();
    thr = 16'hFFFF;
    drain = 1'b1;
    insert(8'h50, 16'd0);
    check("R4", "no arm while draining", armed, 0);
    drain = 1'b0;
    @(negedge clk);
    check("R4", "still unarmed", armed, 0);
    insert(8'h51, 16'd0);
    check("R4", "insert arms", armed, 1);
    repeat (3) @(negedge clk);
    insert(8'h52, 16'd0);
    wait_done(k);
    check("R4", "timer not restarted", k + 4, SPAN);
    check("R7", "recount matches", count_err, 0);
    @(negedge clk);
    remove(8'h50);
    remove(8'h77);
    remove(8'h51);
    wait_done(k);
    check("R6", "period after removes", k + 4, SPAN);
    check("R9", "unmatched remove ignored, still armed", armed, 1);
    check("R7", "recount after removes", count_err, 0);
    @(negedge clk);
    remove(8'h52);
    wait_done(k);
    check("R6", "period to last scan", k + 2, SPAN);
    @(negedge clk);
    check("R6", "disarmed when empty", armed, 0);
    check("R7", "recount at empty", count_err, 0);

    // R8: back-pressure on full line, full table, during scan
    do_reset();
    thr = 16'hFFFF;
    insert(8'h60, 16'd0);
    insert(8'h60, 16'd0);
    ins_addr = 8'h60; #1;
    check("R8", "full line ready", ins_ready, 0);
    insert(8'h61, 16'd0);
    insert(8'h62, 16'd0);
    insert(8'h63, 16'd0);
    ins_addr = 8'h64; #1;
    check("R8", "full table ready", ins_ready, 0);
    ins_addr = 8'h63; #1;
    check("R8", "room on existing line", ins_ready, 1);
    repeat (PERIOD - 4 + 1) @(negedge clk);
    check("R8", "ins_ready during scan", ins_ready, 0);
    check("R9", "rm_ready during scan", rm_ready, 0);
    wait_done(k);
    check("R8", "ready after scan", ins_ready, 1);
    check("R7", "recount at full table", count_err, 0);

    summary();
  end
endmodule